// File: doc/BRIEF.md
# Trap Context Save and Restore Sequencer

This block runs the memory traffic that a processor needs when it enters or leaves an interrupt, trap or software interrupt. On entry it copies the current stack pointer, flag word and instruction pointer into internal registers. It then pushes a four-word frame onto a stack that grows upward. It reads the handler address from a descriptor table at a fixed base address and masks further maskable interrupts. On return it unwinds the same frame and restores the three registers.

The core keeps its own SP, FLG and IP registers. It offers an entry, a return or a flag set/clear command while the sequencer is idle, and it stalls while `busy` is high. When `ctx_load` pulses, the core copies `sp_out`, `flg_out` and `ip_out` into its own registers. Every memory access is a single-word request that stays posted until the memory acknowledges it. Choosing between interrupt sources is done outside this block.

Top module: `trap_seq`

## Requirements
- R1: Each push adds 4 to SP and writes at the new SP. An entry from stack pointer S writes to S+4, S+8, S+12 and S+16, in that order, and reports `sp_out` = S+16.
- R2: The four entry writes carry, in order, the old SP, the flag word as it was when the entry was accepted, the return IP and the error code.
- R3: After the fourth write, the block makes exactly one read at TABLE_BASE + 4*vector, and `ip_out` takes the word that read returns.
- R4: After an entry, `flg_out` equals the captured flag word with the interrupt-enable bit (bit 4) cleared. All other bits are unchanged.
- R5: Vectors 0 to 5 are always accepted. Vectors 6 and above are accepted only while `flg_in[4]` is 1. A rejected request has no effect: `busy` stays low, no memory request is made and `ctx_load` does not pulse.
- R6: A return starting from stack pointer S first drops the error-code slot. It then reads S-4 into IP, S-8 into FLG and S-12 into SP, in that order. `sp_out` becomes the word read from S-12.
- R7: A set-flag or clear-flag command makes no memory access. One cycle later it pulses `ctx_load`, with `flg_out` equal to `flg_in` with bit 4 set or cleared, and with SP and IP unchanged.
- R8: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is high, however long that takes.
- R9: `busy` rises in the cycle after a command is accepted and stays high up to and including the single cycle in which `ctx_load` is high. `busy` is low in the following cycle.
- R10: When several commands arrive together, an acceptable entry wins over a return, a return wins over set-flag, and set-flag wins over clear-flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Request interrupt entry |
| vec | input | 8 | Vector number for the entry |
| err_code | input | 32 | Error code pushed last on entry |
| ret_req | input | 1 | Request interrupt return |
| sif | input | 1 | Set interrupt-enable |
| cif | input | 1 | Clear interrupt-enable |
| sp_in | input | 32 | Current stack pointer |
| flg_in | input | 32 | Current flag word |
| ip_in | input | 32 | Current return IP |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| sp_out | output | 32 | New stack pointer |
| flg_out | output | 32 | New flag word |
| ip_out | output | 32 | New instruction pointer |
| ctx_load | output | 1 | One-cycle strobe: core takes the three outputs |
| busy | output | 1 | Stall the pipeline |

## Verification
On every cycle, the assertions check the 4-byte stride between pushes, the holding of a posted request until it is acknowledged, and that a rejected request leaves `busy` low. They also check that an entry always leaves interrupts masked, that the table read stays inside the table, and that `ctx_load` is a single-cycle pulse covered by `busy`. The order and contents of the frame, the handler address taken from the table, and the exact restore of SP, FLG and IP after a full entry and return can only be shown by the bench scenarios. The bench also covers the acceptance rule for every vector with interrupts enabled and disabled, and the command priorities.

// File: rtl/trap_seq.sv
module trap_seq #(
  parameter int DW = 32,
  parameter int VW = 8,
  parameter logic [31:0] TABLE_BASE = 32'h0000_0800,
  parameter int IE_BIT = 4,
  parameter int FIXED_VECS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [VW-1:0] vec,
  input  logic [DW-1:0] err_code,
  input  logic          ret_req,
  input  logic          sif,
  input  logic          cif,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] flg_in,
  input  logic [DW-1:0] ip_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] sp_out,
  output logic [DW-1:0] flg_out,
  output logic [DW-1:0] ip_out,
  output logic          ctx_load,
  output logic          busy
);

  localparam logic [DW-1:0] WORD = DW'(4);
  localparam logic [DW-1:0] IE_MASK = DW'(1) << IE_BIT;
  localparam logic [DW-1:0] TBL_SPAN = DW'(4) << VW;

  typedef enum logic [2:0] {ST_IDLE, ST_PUSH, ST_TBL, ST_POP, ST_DONE} st_t;

  st_t           state;
  logic [1:0]    step;
  logic          is_entry;
  logic [DW-1:0] sp_r, flg_r, ip_r, sav_sp, err_r;
  logic [VW-1:0] vec_r;
  logic [DW-1:0] push_data;
  logic          take_int;

  assign take_int = (int'(vec) < FIXED_VECS) || flg_in[IE_BIT];

  always_comb begin
    case (step)
      2'd0:    push_data = sav_sp;
      2'd1:    push_data = flg_r;
      2'd2:    push_data = ip_r;
      default: push_data = err_r;
    endcase
  end

  assign mem_req   = (state == ST_PUSH) || (state == ST_TBL) || (state == ST_POP);
  assign mem_we    = (state == ST_PUSH);
  assign mem_addr  = (state == ST_PUSH) ? sp_r + WORD :
                     (state == ST_TBL)  ? TABLE_BASE + {{(DW-VW-2){1'b0}}, vec_r, 2'b00} :
                     sp_r;
  assign mem_wdata = (state == ST_PUSH) ? push_data : '0;
  assign sp_out    = sp_r;
  assign flg_out   = flg_r;
  assign ip_out    = ip_r;
  assign ctx_load  = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step     <= '0;
      is_entry <= 1'b0;
      sp_r     <= '0;
      flg_r    <= '0;
      ip_r     <= '0;
      sav_sp   <= '0;
      err_r    <= '0;
      vec_r    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          step <= '0;
          if (trig && take_int) begin
            sp_r     <= sp_in;
            sav_sp   <= sp_in;
            flg_r    <= flg_in;
            ip_r     <= ip_in;
            err_r    <= err_code;
            vec_r    <= vec;
            is_entry <= 1'b1;
            state    <= ST_PUSH;
          end else if (ret_req) begin
            sp_r     <= sp_in - WORD;
            flg_r    <= flg_in;
            ip_r     <= ip_in;
            is_entry <= 1'b0;
            state    <= ST_POP;
          end else if (sif || cif) begin
            sp_r     <= sp_in;
            ip_r     <= ip_in;
            flg_r    <= sif ? (flg_in | IE_MASK) : (flg_in & ~IE_MASK);
            is_entry <= 1'b0;
            state    <= ST_DONE;
          end
        end
        ST_PUSH: if (mem_ack) begin
          sp_r <= sp_r + WORD;
          step <= step + 2'd1;
          if (step == 2'd3) state <= ST_TBL;
        end
        ST_TBL: if (mem_ack) begin
          ip_r          <= mem_rdata;
          flg_r[IE_BIT] <= 1'b0;
          state         <= ST_DONE;
        end
        ST_POP: if (mem_ack) begin
          step <= step + 2'd1;
          case (step)
            2'd0: begin ip_r  <= mem_rdata; sp_r <= sp_r - WORD; end
            2'd1: begin flg_r <= mem_rdata; sp_r <= sp_r - WORD; end
            default: begin sp_r <= mem_rdata; state <= ST_DONE; end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_push_stride_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH && mem_ack && step != 2'd3) |=> (mem_addr == $past(mem_addr) + WORD));

  assert_tbl_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && is_entry) |-> (mem_addr >= TABLE_BASE && mem_addr < TABLE_BASE + TBL_SPAN));

  assert_entry_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && is_entry) |-> !flg_out[IE_BIT]);

  assert_reject_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && !take_int && !ret_req && !sif && !cif) |=> !busy);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_load_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> !ctx_load);

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || ctx_load) |-> busy);

endmodule

// File: tb/test_trap_seq.sv
module test_trap_seq;
  localparam logic [31:0] BASE = 32'h0000_0800;

  logic clk = 0, rst_n = 0;
  logic trig = 0, ret_req = 0, sif = 0, cif = 0;
  logic [7:0] vec = 0;
  logic [31:0] err_code = 0, sp_in = 0, flg_in = 0, ip_in = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [31:0] sp_out, flg_out, ip_out;
  logic ctx_load, busy;

  always #4 clk = ~clk;

  trap_seq #(.TABLE_BASE(BASE)) i_trap_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .vec(vec), .err_code(err_code),
    .ret_req(ret_req), .sif(sif), .cif(cif), .sp_in(sp_in), .flg_in(flg_in),
    .ip_in(ip_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .sp_out(sp_out), .flg_out(flg_out), .ip_out(ip_out), .ctx_load(ctx_load),
    .busy(busy));

  int n_run = 0, n_fail = 0;
  logic [31:0] mem [0:1023];
  int lat = 0, cnt = 0;
  int wn = 0, rn = 0;
  logic [31:0] wad [0:7], wdt [0:7], rad [0:7];
  bit hold_bad = 0;
  logic [31:0] last_addr = 0;
  bit last_pend = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (last_pend && (!mem_req || mem_addr != last_addr)) hold_bad = 1;
    if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack = 1;
        cnt = 0;
        last_pend = 0;
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          if (wn < 8) begin wad[wn] = mem_addr; wdt[wn] = mem_wdata; end
          wn++;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
          if (rn < 8) rad[rn] = mem_addr;
          rn++;
        end
      end else begin
        mem_ack = 0;
        cnt++;
        last_pend = 1;
        last_addr = mem_addr;
      end
    end else begin
      mem_ack = 0;
      cnt = 0;
      last_pend = 0;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", wd, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wait_load(input string req);
    int k = 0;
    bit bsy_ok = 1;
    chk(busy == 1'b1, "R9 busy rises", busy, 1);
    while (!ctx_load && k < 200) begin
      if (!busy) bsy_ok = 0;
      @(negedge clk);
      k++;
    end
    chk(ctx_load && bsy_ok && busy, {req, " R9 busy until load"}, ctx_load, 1);
  endtask

  task automatic after_load();
    @(negedge clk);
    chk(!busy && !ctx_load, "R9 busy drops after load", {busy, ctx_load}, 0);
  endtask

  task automatic run_entry(input int v, input bit ie);
    logic [31:0] sp0, fl, ip0, er, spn;
    sp0 = 32'h100 + (v % 8) * 32;
    fl  = ({24'h0, 8'(v)} & ~32'h30) | (ie ? 32'h10 : 32'h0) | 32'h0100_0000;
    ip0 = 32'h4000_0000 + v * 4;
    er  = 32'hE000_0000 | v;
    lat = v % 3;
    @(negedge clk);
    vec = 8'(v); err_code = er; sp_in = sp0; flg_in = fl; ip_in = ip0;
    trig = 1; wn = 0; rn = 0; hold_bad = 0;
    @(negedge clk);
    trig = 0;
    if (!(v < 6 || ie)) begin
      bit quiet = !busy;
      for (int k = 0; k < 4; k++) begin
        if (busy || mem_req || ctx_load) quiet = 0;
        @(negedge clk);
      end
      chk(quiet && wn == 0 && rn == 0, "R5 masked request ignored", {busy, mem_req}, 0);
      return;
    end
    wait_load("R5 accepted");
    chk(wn == 4 && wad[0] == sp0 + 4 && wad[1] == sp0 + 8 && wad[2] == sp0 + 12 && wad[3] == sp0 + 16,
        "R1 push addresses", wad[3], sp0 + 16);
    chk(sp_out == sp0 + 16, "R1 sp after entry", sp_out, sp0 + 16);
    chk(wdt[0] == sp0 && wdt[1] == fl && wdt[2] == ip0 && wdt[3] == er, "R2 frame contents", wdt[1], fl);
    chk(rn == 1 && rad[0] == BASE + v * 4, "R3 table address", rad[0], BASE + v * 4);
    chk(ip_out == 32'hA500_0000 + v * 16, "R3 handler ip", ip_out, 32'hA500_0000 + v * 16);
    chk(flg_out == (fl & ~32'h10), "R4 mask on entry", flg_out, fl & ~32'h10);
    chk(!hold_bad, "R8 request held", hold_bad, 0);
    spn = sp_out;
    after_load();
    @(negedge clk);
    sp_in = spn; flg_in = flg_out; ip_in = ip_out; ret_req = 1; wn = 0; rn = 0; hold_bad = 0;
    lat = (v + 1) % 3;
    @(negedge clk);
    ret_req = 0;
    wait_load("R6 return");
    chk(rn == 3 && wn == 0 && rad[0] == spn - 4 && rad[1] == spn - 8 && rad[2] == spn - 12,
        "R6 pop addresses", rad[2], spn - 12);
    chk(ip_out == ip0 && flg_out == fl && sp_out == sp0, "R6 restore", sp_out, sp0);
    chk(!hold_bad, "R8 request held on pop", hold_bad, 0);
    after_load();
  endtask

  task automatic run_flag(input bit set, input logic [31:0] f);
    @(negedge clk);
    sp_in = 32'h1234_5678; ip_in = 32'h8765_4320; flg_in = f;
    sif = set; cif = !set; wn = 0; rn = 0;
    @(negedge clk);
    sif = 0; cif = 0;
    chk(ctx_load && busy, "R7 load one cycle later", ctx_load, 1);
    chk(flg_out == (set ? f | 32'h10 : f & ~32'h10), "R7 flag value", flg_out, set ? f | 32'h10 : f & ~32'h10);
    chk(sp_out == 32'h1234_5678 && ip_out == 32'h8765_4320 && wn == 0 && rn == 0, "R7 no side effect", sp_out, 32'h1234_5678);
    after_load();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    for (int v = 0; v < 256; v++) mem[(BASE >> 2) + v] = 32'hA500_0000 + v * 16;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !ctx_load && sp_out == 0 && ip_out == 0 && flg_out == 0, "reset state", {busy, mem_req, ctx_load}, 0);
    rst_n = 1;
    for (int v = 0; v < 256; v++) run_entry(v, 1);
    for (int v = 0; v < 256; v++) run_entry(v, 0);
    run_flag(1, 32'h0000_000F);
    run_flag(0, 32'hFFFF_FFFF);
    run_flag(1, 32'h0000_0010);
    run_flag(0, 32'h0000_0000);
    // R10: entry beats return and flag commands
    @(negedge clk);
    lat = 1; vec = 8'd3; sp_in = 32'h300; flg_in = 0; ip_in = 32'h55; err_code = 32'h77;
    trig = 1; ret_req = 1; sif = 1; wn = 0; rn = 0;
    @(negedge clk);
    trig = 0; ret_req = 0; sif = 0;
    wait_load("R10 entry first");
    chk(wn == 4 && rn == 1 && sp_out == 32'h310, "R10 entry wins", sp_out, 32'h310);
    after_load();
    // R10: masked entry falls through to return; return beats set-flag
    @(negedge clk);
    vec = 8'd40; sp_in = 32'h310; flg_in = 0; trig = 1; ret_req = 1; sif = 1; cif = 1; wn = 0; rn = 0;
    @(negedge clk);
    trig = 0; ret_req = 0; sif = 0; cif = 0;
    wait_load("R10 return");
    chk(rn == 3 && wn == 0 && sp_out == 32'h300 && ip_out == 32'h55, "R10 return wins", sp_out, 32'h300);
    after_load();
    // R10: set-flag beats clear-flag
    @(negedge clk);
    flg_in = 0; sif = 1; cif = 1;
    @(negedge clk);
    sif = 0; cif = 0;
    chk(ctx_load && flg_out == 32'h10, "R10 set beats clear", flg_out, 32'h10);
    after_load();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule